// File: doc/BRIEF.md
# Per-PC Markov Temporal Prefetcher

This block learns which cache line tends to miss right after another one for the same load instruction, and replays that order later as prefetch requests. Each input event carries a load PC, a 26-bit line address and a kind. Only demand misses and hits on lines that were brought in by a prefetch are used. All other events are taken and dropped. A 64-entry table indexed by PC keeps the last line seen for each PC. When a PC returns, the pair (previous line, current line) is written into a set-associative successor table. The current line is then looked up in that table, and the successor it finds is sent out as a prefetch.

Successor targets are stored in compressed form. The upper 16 line-address bits are kept once, in a shared 1024-slot upper-address table. A successor entry holds only a 10-bit slot index and the 10 low line-address bits. Each trigger keeps one successor, guarded by a one-bit confidence. With a prefetch degree above one, every prefetch produced is used as the trigger for the next lookup. A sequencer runs one event at a time and holds `ev_ready` low while it works. Its states are IDLE, TRAIN, COMPRESS, MKWRITE, LOOKUP and ISSUE. The transitions are:

- IDLE→TRAIN on a miss or prefetched-hit event.
- TRAIN→COMPRESS when the training entry matches the PC.
- TRAIN→LOOKUP when it does not.
- COMPRESS→MKWRITE always.
- MKWRITE→LOOKUP always.
- LOOKUP→ISSUE on a successor hit.
- LOOKUP→IDLE on a miss.
- ISSUE→LOOKUP while the degree is not yet used up.
- ISSUE→IDLE when it is.

Top module: `markov_prefetcher`

## Requirements
- R1: Only `ev_kind` 2'b01 (demand miss) and 2'b10 (hit on a prefetched line) start training and lookup. Kinds 2'b00 and 2'b11 are accepted in one cycle with no prefetch and no change to any table.
- R2: The training table has 64 direct-mapped entries indexed by PC[5:0] and tagged by PC[15:6]. On a tag match, the pair (stored line, current line) is written into the successor table, and the stored line becomes the current line.
- R3: On an empty entry or a PC tag mismatch, the training entry is reloaded with the current PC and line and nothing is written to the successor table. The lookup of the current line still happens.
- R4: After training, the current line is looked up in the successor table. A hit issues its successor as a prefetch.
- R5: The successor table has 64 sets of 4 ways. The set is line[5:0]. The tag is the XOR of line[9:0], line[19:10] and the zero-extended line[25:20].
- R6: Each trigger keeps one successor with a confidence bit. If the same successor is seen again, the bit is set. If a differing successor arrives while the bit is set, the bit is cleared and the old target kept. If a differing successor arrives while the bit is clear, the target is replaced. New and replaced targets start with the bit clear.
- R7: A new trigger takes the lowest-numbered invalid way of its set. In a full set it takes the way named by a per-set pointer, which starts at way 0 and steps by one after each eviction.
- R8: A target's upper 16 bits are found in, or added to, a 1024-slot table. Slots fill in order from 0. Once all are used, slots are reused round-robin from 0, and older targets that name a reused slot decode with the new upper bits.
- R9: The prefetch byte address is {upper bits from the slot, stored 10 low line bits, 6'b0}.
- R10: The degree `cfg_degree` is sampled when the event is taken, with 0 read as 1 and values above 4 read as 4. Lookups chain, each prefetch becoming the next trigger, until that many prefetches are out or a lookup misses. Two prefetches are never on adjacent cycles.
- R11: `ev_ready` is high only while idle. After a miss or prefetched-hit event is taken, it is low on the next cycle, and `pf_valid` is never high while `ev_ready` is high.
- R12: After reset, `ev_ready` is high, `pf_valid` is low, and all tables are empty, so a first event produces no prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block idle and taking an event |
| ev_kind | input | 2 | Event kind (01 miss, 10 prefetched hit, others ignored) |
| ev_pc | input | 16 | PC of the load |
| ev_line | input | 26 | Line address (byte address >> 6) |
| cfg_degree | input | 3 | Requested prefetch degree |
| pf_valid | output | 1 | Prefetch request this cycle |
| pf_addr | output | 32 | Prefetch byte address, line aligned |

## Verification
Short directed sequences come first. One repeats a three-line loop on one PC, which separates training from lookup. Others query the loop from fresh PCs at degrees 0, 3 and 7, which tells chaining and clamping apart. One runs a PC alias that shares an index but not a tag. A trigger that alternates between two successors shows the one-miss hysteresis of the confidence bit. A burst of six triggers in one set shows the order of way victims. A run of over a thousand distinct upper-address values forces slot reuse and shows a stale decoded target. Random events then mix aliased PCs, all four kinds, a small line pool and random degrees. This random phase exercises how all the tables interact, and every output is compared against a reference model in the bench.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRAIN,
        ST_COMPRESS,
        ST_MKWRITE,
        ST_LOOKUP,
        ST_ISSUE
    } mtp_state_e;

    localparam logic [1:0] KIND_MISS  = 2'b01;
    localparam logic [1:0] KIND_PFHIT = 2'b10;

    function automatic logic kind_live(input logic [1:0] k);
        return (k == KIND_MISS) || (k == KIND_PFHIT);
    endfunction

endpackage

// File: rtl/mtp_train_table.sv
module mtp_train_table #(
    parameter int PC_W    = 16,
    parameter int LINE_W  = 26,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   rd_pc,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_prev,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic              ent_v    [ENTRIES];
    logic [TAG_W-1:0]  ent_tag  [ENTRIES];
    logic [LINE_W-1:0] ent_prev [ENTRIES];

    logic [IDX_W-1:0] rd_i, wr_i;

    always_comb begin
        rd_i    = rd_pc[IDX_W-1:0];
        wr_i    = wr_pc[IDX_W-1:0];
        rd_hit  = ent_v[rd_i] && (ent_tag[rd_i] == rd_pc[PC_W-1:IDX_W]);
        rd_prev = ent_prev[rd_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
        end else if (wr_en) begin
            ent_v[wr_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_tag[wr_i]  <= wr_pc[PC_W-1:IDX_W];
            ent_prev[wr_i] <= wr_line;
        end
    end

endmodule

// File: rtl/mtp_upper_table.sv
module mtp_upper_table #(
    parameter int UP_W  = 16,
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [UP_W-1:0]          q_upper,
    output logic                     q_hit,
    output logic [$clog2(DEPTH)-1:0] q_idx,
    input  logic                     alloc_en,
    input  logic [UP_W-1:0]          alloc_upper,
    output logic [$clog2(DEPTH)-1:0] alloc_idx,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [UP_W-1:0]          rd_upper
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic            slot_v  [DEPTH];
    logic [UP_W-1:0] slot_up [DEPTH];
    logic [IDX_W-1:0] rr_ptr;

    // Associative search; the lowest matching slot wins.
    always_comb begin
        q_hit = 1'b0;
        q_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!q_hit && slot_v[i] && (slot_up[i] == q_upper)) begin
                q_hit = 1'b1;
                q_idx = IDX_W'(i);
            end
        end
    end

    // Slots are never freed, so the pointer names a free slot until the table fills.
    assign alloc_idx = rr_ptr;
    assign rd_upper  = slot_up[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) slot_v[i] <= 1'b0;
        end else if (alloc_en) begin
            slot_v[rr_ptr] <= 1'b1;
            rr_ptr         <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_en) slot_up[rr_ptr] <= alloc_upper;
    end

endmodule

// File: rtl/mtp_markov_table.sv
module mtp_markov_table #(
    parameter int LINE_W = 26,
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 10,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_W-1:0]        q_line,
    output logic                     q_hit,
    output logic [$clog2(WAYS)-1:0]  q_way,
    output logic                     q_conf,
    output logic [IDX_W-1:0]         q_tidx,
    output logic [OFF_W-1:0]         q_toff,
    output logic [$clog2(WAYS)-1:0]  q_victim,
    output logic                     q_full,
    input  logic                     wr_en,
    input  logic [LINE_W-1:0]        wr_line,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic                     wr_conf,
    input  logic [IDX_W-1:0]         wr_tidx,
    input  logic [OFF_W-1:0]         wr_toff,
    input  logic                     wr_evict
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    function automatic logic [TAG_W-1:0] fold_tag(input logic [LINE_W-1:0] a);
        logic [TAG_W-1:0] h;
        h = '0;
        for (int b = 0; b < LINE_W; b++) h[b % TAG_W] ^= a[b];
        return h;
    endfunction

    logic             e_v    [SETS][WAYS];
    logic             e_conf [SETS][WAYS];
    logic [TAG_W-1:0] e_tag  [SETS][WAYS];
    logic [IDX_W-1:0] e_tidx [SETS][WAYS];
    logic [OFF_W-1:0] e_toff [SETS][WAYS];
    logic [WAY_W-1:0] rr     [SETS];

    logic [SET_W-1:0] q_set, w_set;
    logic [TAG_W-1:0] q_tag;
    logic             free_found;
    logic [WAY_W-1:0] free_way;

    always_comb begin
        q_set      = q_line[SET_W-1:0];
        q_tag      = fold_tag(q_line);
        q_hit      = 1'b0;
        q_way      = '0;
        free_found = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!q_hit && e_v[q_set][w] && (e_tag[q_set][w] == q_tag)) begin
                q_hit = 1'b1;
                q_way = WAY_W'(w);
            end
            if (!free_found && !e_v[q_set][w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        q_full   = !free_found;
        q_victim = free_found ? free_way : rr[q_set];
        q_conf   = e_conf[q_set][q_way];
        q_tidx   = e_tidx[q_set][q_way];
        q_toff   = e_toff[q_set][q_way];
    end

    assign w_set = wr_line[SET_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr[s] <= '0;
                for (int w = 0; w < WAYS; w++) e_v[s][w] <= 1'b0;
            end
        end else if (wr_en) begin
            e_v[w_set][wr_way] <= 1'b1;
            if (wr_evict) rr[w_set] <= rr[w_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            e_conf[w_set][wr_way] <= wr_conf;
            e_tag[w_set][wr_way]  <= fold_tag(wr_line);
            e_tidx[w_set][wr_way] <= wr_tidx;
            e_toff[w_set][wr_way] <= wr_toff;
        end
    end

endmodule

// File: rtl/markov_prefetcher.sv
module markov_prefetcher
    import mtp_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int LINE_W     = 26,
    parameter int OFF_W      = 10,
    parameter int BYTE_OFS_W = 6,
    parameter int UT_DEPTH   = 1024,
    parameter int TT_ENTRIES = 64,
    parameter int MK_SETS    = 64,
    parameter int MK_WAYS    = 4,
    parameter int TAG_W      = 10,
    parameter int MAX_DEG    = 4,
    parameter int DEG_W      = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_valid,
    output logic                         ev_ready,
    input  logic [1:0]                   ev_kind,
    input  logic [PC_W-1:0]              ev_pc,
    input  logic [LINE_W-1:0]            ev_line,
    input  logic [DEG_W-1:0]             cfg_degree,
    output logic                         pf_valid,
    output logic [LINE_W+BYTE_OFS_W-1:0] pf_addr
);
    localparam int UP_W  = LINE_W - OFF_W;
    localparam int UI_W  = $clog2(UT_DEPTH);
    localparam int WAY_W = $clog2(MK_WAYS);
    localparam logic [DEG_W-1:0] DEG_CAP = DEG_W'(MAX_DEG);

    mtp_state_e state, state_nx;

    logic [PC_W-1:0]   cur_pc;
    logic [LINE_W-1:0] cur_line, prev_line, trig_line, pf_line;
    logic [UI_W-1:0]   tgt_idx;
    logic [DEG_W-1:0]  deg, cnt, deg_in;

    // Training table
    logic              tt_hit, tt_wr_en;
    logic [LINE_W-1:0] tt_prev;

    // Upper-address table
    logic              ut_q_hit, ut_alloc_en;
    logic [UI_W-1:0]   ut_q_idx, ut_alloc_idx;
    logic [UP_W-1:0]   ut_rd_upper;

    // Successor table
    logic              mk_q_hit, mk_q_conf, mk_q_full;
    logic [WAY_W-1:0]  mk_q_way, mk_q_victim;
    logic [UI_W-1:0]   mk_q_tidx;
    logic [OFF_W-1:0]  mk_q_toff;
    logic [LINE_W-1:0] mk_q_line;
    logic              mk_wr_en, mk_wr_conf, mk_wr_evict;
    logic [WAY_W-1:0]  mk_wr_way;
    logic [UI_W-1:0]   mk_wr_tidx;
    logic [OFF_W-1:0]  mk_wr_toff;
    logic              same_tgt;

    mtp_train_table #(
        .PC_W(PC_W), .LINE_W(LINE_W), .ENTRIES(TT_ENTRIES)
    ) u_train (
        .clk(clk), .rst_n(rst_n),
        .rd_pc(cur_pc), .rd_hit(tt_hit), .rd_prev(tt_prev),
        .wr_en(tt_wr_en), .wr_pc(cur_pc), .wr_line(cur_line)
    );

    mtp_upper_table #(
        .UP_W(UP_W), .DEPTH(UT_DEPTH)
    ) u_upper (
        .clk(clk), .rst_n(rst_n),
        .q_upper(cur_line[LINE_W-1:OFF_W]), .q_hit(ut_q_hit), .q_idx(ut_q_idx),
        .alloc_en(ut_alloc_en), .alloc_upper(cur_line[LINE_W-1:OFF_W]),
        .alloc_idx(ut_alloc_idx),
        .rd_idx(mk_q_tidx), .rd_upper(ut_rd_upper)
    );

    mtp_markov_table #(
        .LINE_W(LINE_W), .SETS(MK_SETS), .WAYS(MK_WAYS),
        .TAG_W(TAG_W), .IDX_W(UI_W), .OFF_W(OFF_W)
    ) u_markov (
        .clk(clk), .rst_n(rst_n),
        .q_line(mk_q_line), .q_hit(mk_q_hit), .q_way(mk_q_way),
        .q_conf(mk_q_conf), .q_tidx(mk_q_tidx), .q_toff(mk_q_toff),
        .q_victim(mk_q_victim), .q_full(mk_q_full),
        .wr_en(mk_wr_en), .wr_line(prev_line), .wr_way(mk_wr_way),
        .wr_conf(mk_wr_conf), .wr_tidx(mk_wr_tidx), .wr_toff(mk_wr_toff),
        .wr_evict(mk_wr_evict)
    );

    // Degree clamp applied at event acceptance.
    always_comb begin
        if (cfg_degree == '0)          deg_in = DEG_W'(1);
        else if (cfg_degree > DEG_CAP) deg_in = DEG_CAP;
        else                           deg_in = cfg_degree;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (ev_valid && kind_live(ev_kind)) state_nx = ST_TRAIN;
            ST_TRAIN:    state_nx = tt_hit ? ST_COMPRESS : ST_LOOKUP;
            ST_COMPRESS: state_nx = ST_MKWRITE;
            ST_MKWRITE:  state_nx = ST_LOOKUP;
            ST_LOOKUP:   state_nx = mk_q_hit ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:    state_nx = ((cnt + 1'b1) >= deg) ? ST_IDLE : ST_LOOKUP;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Table control and successor update policy
    always_comb begin
        mk_q_line   = (state == ST_MKWRITE) ? prev_line : trig_line;
        tt_wr_en    = (state == ST_TRAIN);
        ut_alloc_en = (state == ST_COMPRESS) && !ut_q_hit;
        mk_wr_en    = (state == ST_MKWRITE);
        same_tgt    = (mk_q_tidx == tgt_idx) && (mk_q_toff == cur_line[OFF_W-1:0]);
        mk_wr_way   = mk_q_victim;
        mk_wr_conf  = 1'b0;
        mk_wr_tidx  = tgt_idx;
        mk_wr_toff  = cur_line[OFF_W-1:0];
        mk_wr_evict = 1'b0;
        if (mk_q_hit) begin
            mk_wr_way = mk_q_way;
            if (same_tgt) begin
                mk_wr_conf = 1'b1;
            end else if (mk_q_conf) begin
                mk_wr_conf = 1'b0;
                mk_wr_tidx = mk_q_tidx;
                mk_wr_toff = mk_q_toff;
            end
        end else begin
            mk_wr_evict = mk_q_full;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc    <= '0;
            cur_line  <= '0;
            prev_line <= '0;
            trig_line <= '0;
            pf_line   <= '0;
            tgt_idx   <= '0;
            deg       <= DEG_W'(1);
            cnt       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (ev_valid && kind_live(ev_kind)) begin
                    cur_pc    <= ev_pc;
                    cur_line  <= ev_line;
                    trig_line <= ev_line;
                    deg       <= deg_in;
                    cnt       <= '0;
                end
                ST_TRAIN:    prev_line <= tt_prev;
                ST_COMPRESS: tgt_idx   <= ut_q_hit ? ut_q_idx : ut_alloc_idx;
                ST_MKWRITE:  ;
                ST_LOOKUP:   pf_line   <= {ut_rd_upper, mk_q_toff};
                ST_ISSUE: begin
                    cnt       <= cnt + 1'b1;
                    trig_line <= pf_line;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ev_ready = (state == ST_IDLE);
        pf_valid = (state == ST_ISSUE);
        pf_addr  = {pf_line, {BYTE_OFS_W{1'b0}}};
    end

endmodule

// File: rtl/markov_prefetcher_checker.sv
module markov_prefetcher_checker
    import mtp_pkg::*;
#(
    parameter int MAX_DEG = 4,
    parameter int DEG_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_valid,
    input logic             ev_ready,
    input logic [1:0]       ev_kind,
    input logic [DEG_W-1:0] cfg_degree,
    input logic             pf_valid,
    input mtp_state_e       state
);
    logic [DEG_W:0]   seen;
    logic [DEG_W-1:0] allowed;
    logic             took_live;

    assign took_live = ev_valid && ev_ready && kind_live(ev_kind);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen    <= '0;
            allowed <= DEG_W'(1);
        end else if (took_live) begin
            seen    <= '0;
            allowed <= (cfg_degree == '0) ? DEG_W'(1) :
                       (cfg_degree > DEG_W'(MAX_DEG)) ? DEG_W'(MAX_DEG) : cfg_degree;
        end else if (pf_valid) begin
            seen <= seen + 1'b1;
        end
    end

    assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
        took_live |=> (!ev_ready && state == ST_TRAIN));

    assert_quiet_when_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> !pf_valid);

    assert_ignored_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && !kind_live(ev_kind)) |=> (ev_ready && !pf_valid));

    assert_pf_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> !pf_valid);

    assert_degree_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ({1'b0, allowed} > seen));

endmodule

bind markov_prefetcher markov_prefetcher_checker #(
    .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .cfg_degree(cfg_degree), .pf_valid(pf_valid), .state(state)
);

// File: tb/markov_prefetcher_tb.sv
module markov_prefetcher_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [1:0]  ev_kind = 2'b00;
    logic [15:0] ev_pc = '0;
    logic [25:0] ev_line = '0;
    logic [2:0]  cfg_degree = 3'd1;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    markov_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .ev_pc(ev_pc), .ev_line(ev_line),
        .cfg_degree(cfg_degree), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // ---------------- reference model ----------------
    logic        m_tv   [64];
    logic [9:0]  m_ttag [64];
    logic [25:0] m_tprev[64];
    logic        m_mv   [64][4];
    logic        m_mc   [64][4];
    logic [9:0]  m_mtag [64][4];
    logic [9:0]  m_midx [64][4];
    logic [9:0]  m_moff [64][4];
    logic [1:0]  m_rr   [64];
    logic        m_uv   [1024];
    logic [15:0] m_uup  [1024];
    logic [9:0]  m_urr;
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];

    function automatic logic [9:0] hash10(input logic [25:0] a);
        return a[9:0] ^ a[19:10] ^ {4'b0, a[25:20]};
    endfunction

    function automatic int clamp_deg(input logic [2:0] d);
        if (d == 0) return 1;
        if (d > 4) return 4;
        return int'(d);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin
            m_tv[i] = 0; m_rr[i] = 0;
            for (int w = 0; w < 4; w++) m_mv[i][w] = 0;
        end
        for (int i = 0; i < 1024; i++) m_uv[i] = 0;
        m_urr = 0;
    endtask

    task automatic model_find(input logic [25:0] a, output int way);
        way = -1;
        for (int w = 0; w < 4; w++)
            if (way < 0 && m_mv[a[5:0]][w] && m_mtag[a[5:0]][w] == hash10(a)) way = w;
    endtask

    task automatic model_event(input logic [1:0] k, input logic [15:0] pc,
                               input logic [25:0] ln, input logic [2:0] d);
        int ti, idx, way, s, n;
        logic [25:0] x, trig, p;
        exp_q.delete();
        if (!(k == 2'b01 || k == 2'b10)) return;
        ti = int'(pc[5:0]);
        if (m_tv[ti] && m_ttag[ti] == pc[15:6]) begin
            x = m_tprev[ti];
            m_tprev[ti] = ln;
            idx = -1;
            for (int i = 0; i < 1024; i++)
                if (idx < 0 && m_uv[i] && m_uup[i] == ln[25:10]) idx = i;
            if (idx < 0) begin
                idx = int'(m_urr);
                m_uv[idx] = 1; m_uup[idx] = ln[25:10];
                m_urr = m_urr + 1;
            end
            s = int'(x[5:0]);
            model_find(x, way);
            if (way >= 0) begin
                if (m_midx[s][way] == idx[9:0] && m_moff[s][way] == ln[9:0]) m_mc[s][way] = 1;
                else if (m_mc[s][way]) m_mc[s][way] = 0;
                else begin
                    m_midx[s][way] = idx[9:0]; m_moff[s][way] = ln[9:0]; m_mc[s][way] = 0;
                end
            end else begin
                way = -1;
                for (int w = 0; w < 4; w++) if (way < 0 && !m_mv[s][w]) way = w;
                if (way < 0) begin
                    way = int'(m_rr[s]);
                    m_rr[s] = m_rr[s] + 1;
                end
                m_mv[s][way] = 1; m_mc[s][way] = 0; m_mtag[s][way] = hash10(x);
                m_midx[s][way] = idx[9:0]; m_moff[s][way] = ln[9:0];
            end
        end else begin
            m_tv[ti] = 1; m_ttag[ti] = pc[15:6]; m_tprev[ti] = ln;
        end
        trig = ln;
        for (n = 0; n < clamp_deg(d); n++) begin
            model_find(trig, way);
            if (way < 0) break;
            p = {m_uup[m_midx[trig[5:0]][way]], m_moff[trig[5:0]][way]};
            exp_q.push_back({p, 6'b0});
            trig = p;
        end
    endtask

    // ---------------- bench helpers ----------------
    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic do_event(input logic [1:0] k, input logic [15:0] pc,
                            input logic [25:0] ln, input logic [2:0] d, input string req);
        int guard;
        bit same;
        model_event(k, pc, ln, d);
        got_q.delete();
        @(negedge clk);
        guard = 0;
        while (!ev_ready && guard < 100) begin @(negedge clk); guard++; end
        ev_valid = 1; ev_kind = k; ev_pc = pc; ev_line = ln; cfg_degree = d;
        @(negedge clk);
        ev_valid = 0;
        if (k == 2'b01 || k == 2'b10)
            check(ev_ready == 1'b0, "R11",
                  $sformatf("ev_ready after take actual=%0b expected=0", ev_ready));
        guard = 0;
        while (!ev_ready && guard < 200) begin
            if (pf_valid) got_q.push_back(pf_addr);
            @(negedge clk);
            guard++;
        end
        same = (got_q.size() == exp_q.size());
        if (same) foreach (got_q[i]) if (got_q[i] !== exp_q[i]) same = 0;
        check(same && !pf_valid, req,
              $sformatf("prefetches actual n=%0d first=%h expected n=%0d first=%h",
                        got_q.size(), (got_q.size() > 0) ? got_q[0] : 32'h0,
                        exp_q.size(), (exp_q.size() > 0) ? exp_q[0] : 32'h0));
    endtask

    function automatic logic [25:0] mkl(input logic [15:0] up, input logic [9:0] off);
        return {up, off};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    localparam logic [1:0] K_MISS = 2'b01, K_PFH = 2'b10, K_HIT = 2'b00, K_ODD = 2'b11;

    initial begin
        logic [25:0] la, lb, lc, lt, lu, lv;
        logic [15:0] rpcs [6];
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ev_ready == 1 && pf_valid == 0, "R12",
              $sformatf("after reset ready=%0b pf=%0b expected 1/0", ev_ready, pf_valid));

        la = mkl(16'h0011, 10'h041);
        lb = mkl(16'h0022, 10'h082);
        lc = mkl(16'h0011, 10'h0C3);

        // R12: empty tables
        do_event(K_MISS, 16'h0123, la, 3'd1, "R12");
        // R2/R4: loop A B C A
        do_event(K_MISS, 16'h0123, lb, 3'd1, "R2");
        do_event(K_MISS, 16'h0123, lc, 3'd1, "R2");
        do_event(K_PFH,  16'h0123, la, 3'd1, "R4");
        check(got_q.size() == 1 && got_q[0] == {lb, 6'b0}, "R9",
              $sformatf("addr actual=%h expected=%h", (got_q.size() > 0) ? got_q[0] : 32'h0, {lb, 6'b0}));
        // R10: chaining and clamping, fresh PCs (R3: untrained PC still looks up)
        do_event(K_MISS, 16'h0201, la, 3'd3, "R10");
        check(got_q.size() == 3, "R10", $sformatf("chain length actual=%0d expected=3", got_q.size()));
        do_event(K_MISS, 16'h0302, la, 3'd0, "R10");
        do_event(K_MISS, 16'h0403, la, 3'd7, "R10");
        check(got_q.size() == 4, "R10", $sformatf("clamp length actual=%0d expected=4", got_q.size()));
        // R1: ignored kinds leave training state untouched
        do_event(K_HIT, 16'h0123, mkl(16'h0033, 10'h111), 3'd4, "R1");
        do_event(K_ODD, 16'h0123, mkl(16'h0033, 10'h222), 3'd4, "R1");
        do_event(K_MISS, 16'h0123, lb, 3'd1, "R1");
        // R3: alias PC (same index, other tag)
        do_event(K_MISS, 16'h0163, mkl(16'h0044, 10'h155), 3'd1, "R3");
        do_event(K_MISS, 16'h0123, lc, 3'd1, "R3");
        do_event(K_MISS, 16'h0201, lb, 3'd2, "R3");

        // R6: confidence hysteresis
        lt = mkl(16'h0055, 10'h207);
        lu = mkl(16'h0066, 10'h308);
        lv = mkl(16'h0077, 10'h309);
        do_event(K_MISS, 16'h0504, lt, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lu, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lt, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lu, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lt, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lv, 3'd1, "R6");
        do_event(K_MISS, 16'h0605, lt, 3'd1, "R6");
        check(got_q.size() == 1 && got_q[0] == {lu, 6'b0}, "R6",
              $sformatf("kept target actual=%h expected=%h", (got_q.size() > 0) ? got_q[0] : 32'h0, {lu, 6'b0}));
        do_event(K_MISS, 16'h0504, lt, 3'd1, "R6");
        do_event(K_MISS, 16'h0504, lv, 3'd1, "R6");
        do_event(K_MISS, 16'h0706, lt, 3'd1, "R6");
        check(got_q.size() == 1 && got_q[0] == {lv, 6'b0}, "R6",
              $sformatf("replaced target actual=%h expected=%h", (got_q.size() > 0) ? got_q[0] : 32'h0, {lv, 6'b0}));

        // R7/R5: six triggers in one set force way evictions
        for (int i = 0; i < 7; i++)
            do_event(K_MISS, 16'h0807, mkl(16'h0100 + 16'(i), {4'(i), 6'h05}), 3'd1, "R7");
        for (int i = 0; i < 6; i++)
            do_event(K_MISS, 16'h0A10 + 16'(i), mkl(16'h0100 + 16'(i), {4'(i), 6'h05}), 3'd1, "R5");

        // R8: exhaust and wrap the upper-address table
        for (int i = 0; i < 1100; i++)
            do_event(K_MISS, 16'h0908, mkl(16'h2000 + 16'(i), 10'(i * 7)), 3'd1, "R8");
        do_event(K_MISS, 16'h0B20, la, 3'd2, "R8");
        do_event(K_MISS, 16'h0B61, lt, 3'd1, "R8");

        // Random mix
        rpcs[0] = 16'h1100; rpcs[1] = 16'h1140; rpcs[2] = 16'h1201;
        rpcs[3] = 16'h1302; rpcs[4] = 16'h1403; rpcs[5] = 16'h1180;
        for (int i = 0; i < 2500; i++) begin
            logic [15:0] up;
            logic [9:0]  off;
            up  = 16'h3000 + 16'($urandom_range(0, 7));
            off = 10'($urandom_range(0, 39) * 3);
            do_event(2'($urandom_range(0, 3)), rpcs[$urandom_range(0, 5)],
                     mkl(up, off), 3'($urandom_range(0, 7)), "R4");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule